// File: doc/BRIEF.md
# Cascaded Pacer Timer Unit

This block holds three 16-bit down-counters behind a four-address, byte-wide write port. Two of the counters are chained to divide a 2 MHz timebase into a periodic trigger for an analog-to-digital converter. The first chained counter divides the timebase ticks. The second divides the terminal counts of the first. The product of the two divisors sets the trigger period, from 4 ticks up to 65535 × 65535 ticks. The third counter is independent. Its clock, gate and output are board pins, so it can count external events or measure a frequency.

Software first writes a control byte that names a counter. It then writes that counter's divisor as two bytes, low byte first. The 2 MHz timebase reaches the block as a one-cycle enable strobe, `tick_2m`, that is synchronous to the system clock. The external counter clock and gate are asynchronous. They are synchronised inside the block, and the external counter counts rising edges of its clock.

Top module: `pacer_timer_unit`

## Requirements
- R1: After reset `pace_trig` and `ext_out` are low and no counter is loaded. A counter that has never been loaded does not count, so no trigger appears until both chained counters hold a divisor.
- R2: Offsets 0, 1 and 2 carry divisor bytes for the external counter, the first chained counter and the second chained counter. Offset 3 carries the control byte. In the control byte, bits 7:6 select the counter (00, 01, 10) and bits 5:4 must be 11 (low byte then high byte). Bits 3:0 are ignored.
- R3: A control byte with bits 7:6 = 11, or with bits 5:4 other than 11, changes nothing. A divisor byte written to a counter that has not been selected by a valid control byte since reset is ignored.
- R4: Divisor bytes alternate low, high for each counter. A valid control byte for a counter restarts that counter's sequence at the low byte.
- R5: A divisor takes effect on the clock edge that accepts its high byte. The count restarts from the new divisor there. Until then the counter keeps running with its previous divisor.
- R6: The first chained counter decrements on each `tick_2m` and reloads after every N1 ticks. The second decrements on each terminal count of the first. `pace_trig` is high for exactly one cycle, the cycle after the tick that completes N1 × N2 ticks, and repeats with that period.
- R7: A divisor of 0 or 1 is treated as 2 in every counter, so the shortest trigger period is 4 ticks.
- R8: The external counter counts synchronised rising edges of `ext_clk` only while `ext_gate` is high. A low gate freezes its count. `ext_out` gives one single-cycle pulse per N0 counted edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data byte |
| tick_2m | input | 1 | One-cycle 2 MHz timebase strobe |
| ext_clk | input | 1 | Asynchronous clock of the external counter |
| ext_gate | input | 1 | Asynchronous count enable of the external counter |
| ext_out | output | 1 | Terminal pulse of the external counter |
| pace_trig | output | 1 | Converter trigger pulse |

## Verification
The cascade is first driven with a steady tick on every cycle and small directed divisors, which shows the exact N1 × N2 period. Divisors of 0 and 1 then expose the floor of four ticks. Rounds with random divisors and ticks arriving on about 60 % of the cycles compare `pace_trig` cycle by cycle against a reference model, which separates a counter that follows ticks from one that follows the clock. Half-finished byte sequences, repeated control bytes, illegal selects and bad byte-order fields show whether loads commit at the right moment or are wrongly accepted. Gate-high and gate-low bursts of external edges show whether the gate freezes the count or restarts it.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
   // Number of counters; the select code 2'b11 must remain unused.
   localparam int unsigned NUM_CH     = 3;
   localparam logic [1:0]  CTL_OFFSET = 2'd3;
   localparam logic [1:0]  ORDER_LOHI = 2'b11;
   // Index of each role within the counter array.
   localparam int unsigned CH_EXT     = 0;
   localparam int unsigned CH_PRE     = 1;
   localparam int unsigned CH_POST    = 2;
endpackage

// File: rtl/ptu_sync.sv
module ptu_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES > 4) begin : g_bad
      $error("ptu_sync: STAGES above 4 is not supported");
   end

   if (STAGES == 0) begin : g_none
      assign q = d;
   end else if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
         if (!rst_n) s_q <= 1'b0;
         else        s_q <= d;
      end
      assign q = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
   end
endmodule

// File: rtl/ptu_bus_decode.sv
module ptu_bus_decode
   import ptu_pkg::*;
(
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [3:0]        ctl_nib,
   output logic [NUM_CH-1:0] ctl_hit,
   output logic [NUM_CH-1:0] data_hit
);
   logic ctl_ok;
   assign ctl_ok = bus_wr && (bus_addr == CTL_OFFSET) && (ctl_nib[1:0] == ORDER_LOHI);

   always_comb begin
      ctl_hit  = '0;
      data_hit = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (ctl_ok && (ctl_nib[3:2] == 2'(k))) ctl_hit[k] = 1'b1;
         if (bus_wr && (bus_addr == 2'(k)))     data_hit[k] = 1'b1;
      end
   end
endmodule

// File: rtl/ptu_down_stage.sv
module ptu_down_stage #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MIN_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_hit,
   input  logic              data_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              count_en,
   output logic              term,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              loaded_o,
   output logic              armed_o
);
   localparam logic [CNT_W-1:0] DIV_FLOOR = CNT_W'(MIN_DIV);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(1);

   if (CNT_W != 2 * DATA_W) begin : g_bad_w
      $error("ptu_down_stage: CNT_W must be twice DATA_W");
   end
   if (MIN_DIV < 2) begin : g_bad_min
      $error("ptu_down_stage: MIN_DIV must be at least 2");
   end

   logic              armed_q, hi_next_q, loaded_q;
   logic [DATA_W-1:0] lo_q;
   logic [CNT_W-1:0]  div_q, cnt_q, raw_div, div_new;
   logic              load_now;

   assign raw_div  = {wr_data, lo_q};
   assign div_new  = (raw_div < DIV_FLOOR) ? DIV_FLOOR : raw_div;
   assign load_now = data_hit && armed_q && hi_next_q;
   assign term     = count_en && loaded_q && (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         hi_next_q <= 1'b0;
         loaded_q  <= 1'b0;
         lo_q      <= '0;
         div_q     <= '0;
         cnt_q     <= '0;
      end else begin
         if (ctl_hit) begin
            armed_q   <= 1'b1;
            hi_next_q <= 1'b0;
         end else if (data_hit && armed_q) begin
            if (!hi_next_q) lo_q <= wr_data;
            hi_next_q <= !hi_next_q;
         end

         if (load_now) begin
            div_q    <= div_new;
            cnt_q    <= div_new;
            loaded_q <= 1'b1;
         end else if (term) begin
            cnt_q <= div_q;
         end else if (count_en && loaded_q) begin
            cnt_q <= cnt_q - CNT_LAST;
         end
      end
   end

   assign cnt_o    = cnt_q;
   assign loaded_o = loaded_q;
   assign armed_o  = armed_q;
endmodule

// File: rtl/pacer_timer_unit.sv
module pacer_timer_unit
   import ptu_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MIN_DIV     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              tick_2m,
   input  logic              ext_clk,
   input  logic              ext_gate,
   output logic              ext_out,
   output logic              pace_trig
);
   if (DATA_W < 4) begin : g_bad_data
      $error("pacer_timer_unit: DATA_W must hold a 4-bit control field");
   end

   logic [NUM_CH-1:0]            ctl_hit, data_hit, st_en, st_term, st_loaded, st_armed;
   logic [NUM_CH-1:0][CNT_W-1:0] st_cnt;
   logic                         clk_s, gate_s, clk_prev_q, ext_rise;
   logic                         ext_q, pace_q;

   ptu_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(clk_s));
   ptu_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .d(ext_gate), .q(gate_s));

   always_ff @(posedge clk) begin
      if (!rst_n) clk_prev_q <= 1'b0;
      else        clk_prev_q <= clk_s;
   end
   assign ext_rise = clk_s && !clk_prev_q;

   ptu_bus_decode u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .ctl_nib  (bus_wdata[DATA_W-1:DATA_W-4]),
      .ctl_hit  (ctl_hit),
      .data_hit (data_hit)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      if (k == CH_EXT) begin : g_en_ext
         assign st_en[k] = ext_rise && gate_s;
      end else if (k == CH_PRE) begin : g_en_pre
         assign st_en[k] = tick_2m;
      end else begin : g_en_post
         assign st_en[k] = st_term[k-1];
      end

      ptu_down_stage #(
         .CNT_W   (CNT_W),
         .DATA_W  (DATA_W),
         .MIN_DIV (MIN_DIV)
      ) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctl_hit  (ctl_hit[k]),
         .data_hit (data_hit[k]),
         .wr_data  (bus_wdata),
         .count_en (st_en[k]),
         .term     (st_term[k]),
         .cnt_o    (st_cnt[k]),
         .loaded_o (st_loaded[k]),
         .armed_o  (st_armed[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q  <= 1'b0;
         pace_q <= 1'b0;
      end else begin
         ext_q  <= st_term[CH_EXT];
         pace_q <= st_term[CH_POST];
      end
   end

   assign ext_out   = ext_q;
   assign pace_trig = pace_q;
endmodule

// File: rtl/ptu_checker.sv
module ptu_checker
   import ptu_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_wr,
   input logic [1:0]                   bus_addr,
   input logic [DATA_W-1:0]            bus_wdata,
   input logic                         tick_2m,
   input logic                         ext_out,
   input logic                         pace_trig,
   input logic [NUM_CH-1:0][CNT_W-1:0] st_cnt,
   input logic [NUM_CH-1:0]            st_loaded,
   input logic [NUM_CH-1:0]            st_armed
);
   // R6: trigger is a single-cycle pulse
   p_pace_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pace_trig |=> !pace_trig);

   // R6: a trigger only follows a timebase tick
   p_pace_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pace_trig |-> $past(tick_2m));

   // R8: external counter pulse is a single cycle
   p_ext_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_out |=> !ext_out);

   // R5: the first chained count moves only on a tick or a write
   p_pre_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_2m && !bus_wr) |=> $stable(st_cnt[CH_PRE]));

   // R3: an illegal select leaves every counter's arming unchanged
   p_illegal_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTL_OFFSET && bus_wdata[DATA_W-1 -: 2] == 2'b11)
      |=> $stable(st_armed));

   // R3: a byte for an unselected counter never loads it
   p_unarmed_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'(CH_PRE) && !st_armed[CH_PRE] && !st_loaded[CH_PRE])
      |=> !st_loaded[CH_PRE]);

   for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
      // R7: a loaded counter never sits at zero
      p_loaded_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
         st_loaded[k] |-> (st_cnt[k] != '0));
   end
endmodule

bind pacer_timer_unit ptu_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .tick_2m   (tick_2m),
   .ext_out   (ext_out),
   .pace_trig (pace_trig),
   .st_cnt    (st_cnt),
   .st_loaded (st_loaded),
   .st_armed  (st_armed)
);

// File: tb/sim_pacer_timer_unit.sv
module sim_pacer_timer_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic       tick_2m = 1'b0;
   logic       ext_clk = 1'b0;
   logic       ext_gate = 1'b0;
   logic       ext_out, pace_trig;

   int n_checks = 0;
   int n_fail   = 0;
   int ext_cnt  = 0;
   string cur_req = "R1";
   logic exp_pace = 1'b0;

   // reference model of the two chained counters (and arming of all three)
   bit [2:0] m_arm = '0, m_ph = '0, m_ld = '0;
   int m_lo [3];
   int m_div[3];
   int m_cnt[3];

   always #5 clk = ~clk;

   pacer_timer_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .tick_2m(tick_2m), .ext_clk(ext_clk),
      .ext_gate(ext_gate), .ext_out(ext_out), .pace_trig(pace_trig));

   always @(posedge clk) if (rst_n && ext_out) ext_cnt++;

   function automatic void model_write(logic [1:0] a, logic [7:0] d);
      int n;
      if (a == 2'd3) begin
         if (d[7:6] != 2'b11 && d[5:4] == 2'b11) begin
            m_arm[d[7:6]] = 1'b1;
            m_ph[d[7:6]]  = 1'b0;
         end
      end else if (m_arm[a]) begin
         if (!m_ph[a]) begin
            m_lo[a] = int'(d);
            m_ph[a] = 1'b1;
         end else begin
            m_ph[a] = 1'b0;
            n = int'(d) * 256 + m_lo[a];
            if (n < 2) n = 2;
            m_div[a] = n;
            m_cnt[a] = n;
            m_ld[a]  = 1'b1;
         end
      end
   endfunction

   function automatic logic model_tick();
      logic t1, t2;
      t1 = m_ld[1] && (m_cnt[1] == 1);
      if (m_ld[1]) m_cnt[1] = t1 ? m_div[1] : m_cnt[1] - 1;
      t2 = t1 && m_ld[2] && (m_cnt[2] == 1);
      if (t1 && m_ld[2]) m_cnt[2] = t2 ? m_div[2] : m_cnt[2] - 1;
      return t2;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: check the previous cycle's trigger, then drive the next inputs
   task automatic drive(input logic tk, input logic we, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      chk(cur_req, int'(pace_trig), int'(exp_pace));
      tick_2m   = tk;
      bus_wr    = we;
      bus_addr  = a;
      bus_wdata = d;
      if (we) model_write(a, d);
      exp_pace = tk ? model_tick() : 1'b0;
   endtask

   task automatic idle(input int n, input logic tk);
      for (int i = 0; i < n; i++) drive(tk, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      drive(1'b0, 1'b1, a, d);
   endtask

   task automatic load(input logic [1:0] ch, input int n);
      wr(2'd3, {ch, 2'b11, 4'b0000});
      wr(ch, 8'(n));
      wr(ch, 8'(n >> 8));
   endtask

   task automatic ext_edges(input int n);
      for (int i = 0; i < n; i++) begin
         ext_clk = 1'b1;
         idle(4, 1'b0);
         ext_clk = 1'b0;
         idle(4, 1'b0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int base;
      void'($urandom(32'h5EED));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state at the ports
      chk("R1 pace", int'(pace_trig), 0);
      chk("R1 ext", int'(ext_out), 0);

      // R3: bad order field and illegal select leave counter 1 unloaded
      cur_req = "R1 R3";
      load(2'd2, 2);
      wr(2'd3, 8'h50);
      wr(2'd1, 8'd3);
      wr(2'd1, 8'd0);
      wr(2'd3, 8'hF0);
      wr(2'd1, 8'd3);
      wr(2'd1, 8'd0);
      idle(20, 1'b1);

      // R2 R6: mode bits set in the control byte; period 3 x 2
      cur_req = "R2 R6";
      wr(2'd3, 8'h7F);
      wr(2'd1, 8'd3);
      wr(2'd1, 8'd0);
      idle(30, 1'b1);

      // R5: only the low byte written, old divisor keeps running
      cur_req = "R5";
      wr(2'd3, 8'h70);
      wr(2'd1, 8'd5);
      idle(13, 1'b1);
      wr(2'd1, 8'd0);
      idle(30, 1'b1);

      // R4: a second control byte restarts the byte sequence
      cur_req = "R4";
      wr(2'd3, 8'h70);
      wr(2'd1, 8'd9);
      wr(2'd3, 8'h70);
      wr(2'd1, 8'd4);
      wr(2'd1, 8'd0);
      idle(24, 1'b1);

      // R7: divisors 1 and 0 both clamp to 2, period 4
      cur_req = "R7";
      load(2'd1, 1);
      load(2'd2, 0);
      idle(20, 1'b1);

      // R6: random divisors, sparse random ticks
      cur_req = "R6 random";
      for (int r = 0; r < 8; r++) begin
         load(2'd1, int'($urandom_range(0, 6)));
         load(2'd2, int'($urandom_range(0, 6)));
         for (int c = 0; c < 200; c++) drive(($urandom_range(0, 9) < 6), 1'b0, 2'd0, 8'd0);
      end

      // R8: external counter with gate
      cur_req = "R8";
      ext_gate = 1'b1;
      load(2'd0, 5);
      idle(4, 1'b0);
      base = ext_cnt;
      ext_edges(12);
      chk("R8 gate high", ext_cnt - base, 2);
      ext_gate = 1'b0;
      idle(4, 1'b0);
      base = ext_cnt;
      ext_edges(7);
      chk("R8 gate low", ext_cnt - base, 0);
      ext_gate = 1'b1;
      idle(4, 1'b0);
      base = ext_cnt;
      ext_edges(3);
      chk("R8 resumed", ext_cnt - base, 1);

      idle(4, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule